// File: doc/BRIEF.md
# Non-Posted Request Completion Tracker

This block sits on the requester side of a packet-based I/O link and keeps track of requests that must be answered by a completion. When the device core issues a memory read or an IO write, the tracker hands out a free tag. It records against that tag the completion it expects (with data for a read, without data for an IO write) and the requested length in doublewords. Memory writes and messages are posted. They pass through with no tag and never wait for an answer.

Each incoming completion is tested in a fixed order. Completions addressed to another requester identifier are ignored. Completions that name a tag not in use, or whose data/no-data form does not fit the outstanding request, are dropped and flagged as unexpected. Every other completion retires its tag and produces one response to the core. That response carries the tag, the recorded length, a result code and the received status. Data is released to the core only for a successful completion of a read. Every live tag runs its own cycle counter, and an entry that waits too long is retired with a timeout result. The tracker also checks request lengths and reports malformed requests. Such requests are accepted but never tracked.

Top module: `np_cpl_tracker`

## Requirements
- R1: Posted requests (`req_kind` 2 = memory write, 3 = message) always see `req_ready` high, allocate no tag and leave `req_tag` unchanged.
- R2: A well-formed non-posted request (`req_kind` 0 = memory read, 1 = IO write) that is accepted takes the lowest-numbered free tag, which `req_tag` shows before the accepting edge.
- R3: While all NUM_TAGS tags are in use, `req_ready` is low for well-formed non-posted requests and stays high for posted ones. Freeing any tag raises it again.
- R4: A memory write longer than 1024 DW, a memory read of 0 or more than 1024 DW, and an IO write of any length other than 1 DW are accepted without a tag. Each of them pulses `req_malformed` in the cycle after acceptance.
- R5: A completion whose `cpl_req_id` differs from `local_id` produces no response, no unexpected flag and does not retire its tag.
- R6: A completion with status 0 (successful) whose form matches the entry (data for a read, none for an IO write) gives, one cycle later, `rsp_valid` with `rsp_code` 0, the tag, the recorded length, and `rsp_data_en` high only for a read. The tag is freed.
- R7: A completion without data and with nonzero status retires a live tag of either kind with `rsp_code` 1, echoes the status on `rsp_status` and keeps `rsp_data_en` low.
- R8: A completion addressed to this requester that names a free tag, carries data for an IO write, carries data with a nonzero status, or carries no data with status 0 for a read, pulses `unexp_cpl` one cycle later. It gives no response and leaves the entry live.
- R9: A tag allocated at clock edge k and never completed is reported with `rsp_code` 2 and freed. `rsp_valid` for it is high after edge k+TMO_LIMIT+1.
- R10: When a completion is accepted in the same cycle as a pending timeout, the completion is reported first and the timeout is reported in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | ID_W | This requester's identifier |
| req_valid | input | 1 | Request offered by the core |
| req_kind | input | 2 | 0 memory read, 1 IO write, 2 memory write, 3 message |
| req_len_dw | input | LEN_W | Request length in doublewords |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_tag | output | TAG_W | Tag the next non-posted request would receive |
| cpl_valid | input | 1 | Completion present |
| cpl_req_id | input | ID_W | Requester identifier carried by the completion |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cpl_has_data | input | 1 | Completion carries a payload |
| cpl_status | input | 3 | Completion status, 0 = successful |
| rsp_valid | output | 1 | Response to the core this cycle |
| rsp_tag | output | TAG_W | Tag that was retired |
| rsp_code | output | 2 | 0 done, 1 completion error, 2 timeout |
| rsp_status | output | 3 | Status of the completion (0 on timeout) |
| rsp_data_en | output | 1 | Core may take the completion's data |
| rsp_len_dw | output | LEN_W | Length recorded at allocation |
| unexp_cpl | output | 1 | Completion was dropped as unexpected |
| req_malformed | output | 1 | Accepted request had an illegal length |

## Verification
The bench fills every tag, then retires the tags in a scrambled order. A wrong priority encoder or a missed free shows up as a wrong `req_tag` or a stuck `req_ready`. It walks each length limit on both sides, so an off-by-one limit would either track a malformed request or flag a legal one. It sends completions that carry a foreign identifier, a free tag, or the wrong data form, and then shows the entry is still live. A design that retired on any of these would answer the later legitimate completion as unexpected. Two timed cases finish the run. One counts the exact cycle of a timeout. The other collides a timeout with an accepted completion, where a design without a deferred report would lose one of the two responses.

// File: rtl/np_trk_pkg.sv
package np_trk_pkg;

    typedef enum logic [1:0] {
        KIND_MRD  = 2'd0,
        KIND_IOWR = 2'd1,
        KIND_MWR  = 2'd2,
        KIND_MSG  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_CPL_ERR = 2'd1,
        RSP_TIMEOUT = 2'd2
    } rsp_code_e;

    localparam logic [2:0] CPL_ST_SUCCESS = 3'd0;
    localparam int         MAX_PAYLOAD_DW = 1024;
    localparam int         IO_LEN_DW      = 1;

    function automatic logic kind_is_posted(input req_kind_e k);
        return (k == KIND_MWR) || (k == KIND_MSG);
    endfunction

endpackage

// File: rtl/np_low_pick.sv
module np_low_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/np_cpl_check.sv
module np_cpl_check
    import np_trk_pkg::*;
#(
    parameter int N    = 8,
    parameter int W    = 3,
    parameter int ID_W = 16
) (
    input  logic            cpl_valid,
    input  logic [ID_W-1:0] cpl_req_id,
    input  logic [ID_W-1:0] local_id,
    input  logic [W-1:0]    cpl_tag,
    input  logic            cpl_has_data,
    input  logic [2:0]      cpl_status,
    input  logic [N-1:0]    ent_live,
    input  logic [N-1:0]    ent_want_data,
    output logic            accept,
    output logic            unexpected,
    output logic            status_bad
);
    logic ours;
    logic tag_live;
    logic want_data;
    logic form_ok;

    always_comb begin
        ours      = cpl_valid && (cpl_req_id == local_id);
        tag_live  = 1'b0;
        want_data = 1'b0;
        if (int'(cpl_tag) < N) begin
            tag_live  = ent_live[cpl_tag];
            want_data = ent_want_data[cpl_tag];
        end
        status_bad = (cpl_status != CPL_ST_SUCCESS);
        // error completions never carry a payload
        form_ok    = status_bad ? !cpl_has_data : (cpl_has_data == want_data);
        accept     = ours && tag_live && form_ok;
        unexpected = ours && !(tag_live && form_ok);
    end
endmodule

// File: rtl/np_cpl_tracker.sv
module np_cpl_tracker
    import np_trk_pkg::*;
#(
    parameter int NUM_TAGS  = 8,
    parameter int ID_W      = 16,
    parameter int LEN_W     = 11,
    parameter int TMO_LIMIT = 50000,
    localparam int TAG_W    = $clog2(NUM_TAGS),
    localparam int CNT_W    = $clog2(TMO_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  local_id,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [LEN_W-1:0] req_len_dw,
    output logic             req_ready,
    output logic [TAG_W-1:0] req_tag,
    input  logic             cpl_valid,
    input  logic [ID_W-1:0]  cpl_req_id,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic             cpl_has_data,
    input  logic [2:0]       cpl_status,
    output logic             rsp_valid,
    output logic [TAG_W-1:0] rsp_tag,
    output logic [1:0]       rsp_code,
    output logic [2:0]       rsp_status,
    output logic             rsp_data_en,
    output logic [LEN_W-1:0] rsp_len_dw,
    output logic             unexp_cpl,
    output logic             req_malformed
);

    typedef struct packed {
        logic             live;
        logic             want_data;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] age;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_TAGS-1:0] ent;
        logic                  rsp_vld;
        logic [TAG_W-1:0]      rsp_tag;
        logic [1:0]            rsp_code;
        logic [2:0]            rsp_status;
        logic                  rsp_data_en;
        logic [LEN_W-1:0]      rsp_len;
        logic                  unexp;
        logic                  malformed;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_TAGS-1:0] live_vec, want_vec, free_vec, expired_vec;
    logic                free_any, tmo_any;
    logic [TAG_W-1:0]    free_idx, tmo_idx;
    logic                cpl_accept, cpl_unexp, cpl_err;

    genvar g;
    generate
        for (g = 0; g < NUM_TAGS; g++) begin : g_ent
            assign live_vec[g]    = s_q.ent[g].live;
            assign want_vec[g]    = s_q.ent[g].want_data;
            assign free_vec[g]    = !s_q.ent[g].live;
            assign expired_vec[g] = s_q.ent[g].live &&
                                    (s_q.ent[g].age == CNT_W'(TMO_LIMIT));
        end
    endgenerate

    np_low_pick #(.N(NUM_TAGS), .W(TAG_W)) i_free_pick (
        .req   (free_vec),
        .found (free_any),
        .idx   (free_idx)
    );

    np_low_pick #(.N(NUM_TAGS), .W(TAG_W)) i_tmo_pick (
        .req   (expired_vec),
        .found (tmo_any),
        .idx   (tmo_idx)
    );

    np_cpl_check #(.N(NUM_TAGS), .W(TAG_W), .ID_W(ID_W)) i_cpl_check (
        .cpl_valid     (cpl_valid),
        .cpl_req_id    (cpl_req_id),
        .local_id      (local_id),
        .cpl_tag       (cpl_tag),
        .cpl_has_data  (cpl_has_data),
        .cpl_status    (cpl_status),
        .ent_live      (live_vec),
        .ent_want_data (want_vec),
        .accept        (cpl_accept),
        .unexpected    (cpl_unexp),
        .status_bad    (cpl_err)
    );

    req_kind_e kind;
    logic      posted;
    logic      len_bad;
    logic      req_fire;

    always_comb begin
        kind   = req_kind_e'(req_kind);
        posted = kind_is_posted(kind);
        unique case (kind)
            KIND_MRD:  len_bad = (req_len_dw == '0) ||
                                 (int'(req_len_dw) > MAX_PAYLOAD_DW);
            KIND_IOWR: len_bad = (int'(req_len_dw) != IO_LEN_DW);
            KIND_MWR:  len_bad = (int'(req_len_dw) > MAX_PAYLOAD_DW);
            default:   len_bad = 1'b0;
        endcase
        req_ready = posted || len_bad || free_any;
        req_tag   = free_idx;
        req_fire  = req_valid && req_ready;

        s_d             = s_q;
        s_d.rsp_vld     = 1'b0;
        s_d.rsp_data_en = 1'b0;
        s_d.unexp       = 1'b0;
        s_d.malformed   = 1'b0;

        // age every live entry, saturating at the limit
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (s_q.ent[i].live && (s_q.ent[i].age != CNT_W'(TMO_LIMIT)))
                s_d.ent[i].age = s_q.ent[i].age + 1'b1;
        end

        if (req_fire) begin
            if (len_bad) begin
                s_d.malformed = 1'b1;
            end else if (!posted) begin
                s_d.ent[free_idx].live      = 1'b1;
                s_d.ent[free_idx].want_data = (kind == KIND_MRD);
                s_d.ent[free_idx].len       = req_len_dw;
                s_d.ent[free_idx].age       = '0;
            end
        end

        s_d.unexp = cpl_unexp;

        if (cpl_accept) begin
            s_d.ent[cpl_tag].live = 1'b0;
            s_d.rsp_vld     = 1'b1;
            s_d.rsp_tag     = cpl_tag;
            s_d.rsp_code    = cpl_err ? RSP_CPL_ERR : RSP_OK;
            s_d.rsp_status  = cpl_status;
            s_d.rsp_data_en = !cpl_err && s_q.ent[cpl_tag].want_data;
            s_d.rsp_len     = s_q.ent[cpl_tag].len;
        end else if (tmo_any) begin
            s_d.ent[tmo_idx].live = 1'b0;
            s_d.rsp_vld     = 1'b1;
            s_d.rsp_tag     = tmo_idx;
            s_d.rsp_code    = RSP_TIMEOUT;
            s_d.rsp_status  = CPL_ST_SUCCESS;
            s_d.rsp_len     = s_q.ent[tmo_idx].len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid     = s_q.rsp_vld;
    assign rsp_tag       = s_q.rsp_tag;
    assign rsp_code      = s_q.rsp_code;
    assign rsp_status    = s_q.rsp_status;
    assign rsp_data_en   = s_q.rsp_data_en;
    assign rsp_len_dw    = s_q.rsp_len;
    assign unexp_cpl     = s_q.unexp;
    assign req_malformed = s_q.malformed;

endmodule

// File: rtl/np_trk_checker.sv
module np_trk_checker #(
    parameter int ID_W  = 16,
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ID_W-1:0]  local_id,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [LEN_W-1:0] req_len_dw,
    input logic             req_ready,
    input logic             cpl_valid,
    input logic [ID_W-1:0]  cpl_req_id,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic             rsp_data_en,
    input logic             unexp_cpl,
    input logic             req_malformed
);
    AST_POSTED_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind[1] |-> req_ready); // R1

    AST_LONG_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind == 2'd2) && (int'(req_len_dw) > 1024) |=> req_malformed); // R4

    AST_FOREIGN_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && (cpl_req_id != local_id) |=> !unexp_cpl); // R5

    AST_DATA_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data_en |-> rsp_valid && (rsp_code == 2'd0)); // R6

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_code != 2'd0) |-> !rsp_data_en); // R7
endmodule

bind np_cpl_tracker np_trk_checker #(.ID_W(ID_W), .LEN_W(LEN_W)) i_trk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .local_id      (local_id),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_len_dw    (req_len_dw),
    .req_ready     (req_ready),
    .cpl_valid     (cpl_valid),
    .cpl_req_id    (cpl_req_id),
    .rsp_valid     (rsp_valid),
    .rsp_code      (rsp_code),
    .rsp_data_en   (rsp_data_en),
    .unexp_cpl     (unexp_cpl),
    .req_malformed (req_malformed)
);

// File: tb/test_np_cpl_tracker.sv
`timescale 1ns/1ps
module test_np_cpl_tracker;
    localparam int NT   = 8;
    localparam int TW   = 3;
    localparam int IDW  = 16;
    localparam int LW   = 11;
    localparam int LIM  = 60;
    localparam logic [IDW-1:0] LID = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IDW-1:0] local_id = LID;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [LW-1:0] req_len_dw = '0;
    logic req_ready;
    logic [TW-1:0] req_tag;
    logic cpl_valid = 1'b0;
    logic [IDW-1:0] cpl_req_id = '0;
    logic [TW-1:0] cpl_tag = '0;
    logic cpl_has_data = 1'b0;
    logic [2:0] cpl_status = '0;
    logic rsp_valid;
    logic [TW-1:0] rsp_tag;
    logic [1:0] rsp_code;
    logic [2:0] rsp_status;
    logic rsp_data_en;
    logic [LW-1:0] rsp_len_dw;
    logic unexp_cpl;
    logic req_malformed;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    np_cpl_tracker #(.NUM_TAGS(NT), .ID_W(IDW), .LEN_W(LW), .TMO_LIMIT(LIM)) i_np_cpl_tracker (
        .clk(clk), .rst_n(rst_n), .local_id(local_id),
        .req_valid(req_valid), .req_kind(req_kind), .req_len_dw(req_len_dw),
        .req_ready(req_ready), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_req_id(cpl_req_id), .cpl_tag(cpl_tag),
        .cpl_has_data(cpl_has_data), .cpl_status(cpl_status),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_code(rsp_code),
        .rsp_status(rsp_status), .rsp_data_en(rsp_data_en), .rsp_len_dw(rsp_len_dw),
        .unexp_cpl(unexp_cpl), .req_malformed(req_malformed)
    );

    task automatic check(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0;
        req_kind = 2'd0; req_len_dw = 11'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic peek(input int k, input int len);
        req_kind = k[1:0]; req_len_dw = len[LW-1:0];
        #1;
    endtask

    task automatic send_req(input int k, input int len);
        req_kind = k[1:0]; req_len_dw = len[LW-1:0]; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_cpl(input logic [IDW-1:0] id, input int tag, input bit dat, input int st);
        cpl_req_id = id; cpl_tag = tag[TW-1:0]; cpl_has_data = dat;
        cpl_status = st[2:0]; cpl_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string what, input int tag, input int code,
                              input int st, input int den, input int len);
        check({what, " rsp_valid"}, rsp_valid, 1);
        check({what, " rsp_tag"}, rsp_tag, tag);
        check({what, " rsp_code"}, rsp_code, code);
        check({what, " rsp_status"}, rsp_status, st);
        check({what, " rsp_data_en"}, rsp_data_en, den);
        check({what, " rsp_len"}, rsp_len_dw, len);
        check({what, " unexp"}, unexp_cpl, 0);
    endtask

    initial begin
        #(20000 * 10);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int k0;
        int seen;
        do_reset();
        // reset state
        peek(0, 1);
        check("reset req_ready", req_ready, 1);
        check("reset req_tag", req_tag, 0);
        check("reset rsp_valid", rsp_valid, 0);
        check("reset unexp", unexp_cpl, 0);

        // R1: posted requests take no tag
        send_req(2, 16);
        send_req(3, 0);
        peek(0, 1);
        check("R1 tag after posted", req_tag, 0);
        check("R1 no malformed", req_malformed, 0);
        check("R1 no response", rsp_valid, 0);

        // R2/R3: fill all tags
        for (int t = 0; t < NT; t++) begin
            peek(0, t + 1);
            check("R2 lowest free tag", req_tag, t);
            check("R2 ready", req_ready, 1);
            send_req(0, t + 1);
        end
        peek(0, 4);
        check("R3 read stalls when full", req_ready, 0);
        peek(1, 1);
        check("R3 io write stalls when full", req_ready, 0);
        peek(2, 4);
        check("R3 posted ready when full", req_ready, 1);
        send_req(2, 4);
        check("R1 posted while full no flag", req_malformed, 0);

        // R6: retire in scrambled order
        for (int t = 0; t < NT; t++) begin
            int tg;
            tg = (t * 3) % NT;
            send_cpl(LID, tg, 1'b1, 0);
            expect_rsp("R6 read ok", tg, 0, 0, 1, tg + 1);
            if (t == 0) begin
                peek(0, 1);
                check("R3 ready after free", req_ready, 1);
                check("R2 freed tag reused", req_tag, tg);
            end
        end
        peek(0, 1);
        check("R2 all free again", req_tag, 0);

        // R6: IO write success
        send_req(1, 1);
        send_cpl(LID, 0, 1'b0, 0);
        expect_rsp("R6 io ok", 0, 0, 0, 0, 1);

        // R7: error statuses
        send_req(0, 33);
        send_cpl(LID, 0, 1'b0, 1);
        expect_rsp("R7 read err", 0, 1, 1, 0, 33);
        send_req(1, 1);
        send_cpl(LID, 0, 1'b0, 2);
        expect_rsp("R7 io err", 0, 1, 2, 0, 1);

        // R8: unexpected completions
        do_reset();
        send_cpl(LID, 3, 1'b1, 0);
        check("R8 free tag unexp", unexp_cpl, 1);
        check("R8 free tag no rsp", rsp_valid, 0);
        send_req(0, 5);
        send_req(1, 1);
        send_cpl(LID, 0, 1'b0, 0);
        check("R8 read no data unexp", unexp_cpl, 1);
        check("R8 read no data no rsp", rsp_valid, 0);
        send_cpl(LID, 1, 1'b1, 0);
        check("R8 io with data unexp", unexp_cpl, 1);
        send_cpl(LID, 0, 1'b1, 4);
        check("R8 error with data unexp", unexp_cpl, 1);
        peek(0, 1);
        check("R8 entries kept", req_tag, 2);
        send_cpl(LID, 0, 1'b1, 0);
        expect_rsp("R8 read still live", 0, 0, 0, 1, 5);
        send_cpl(LID, 1, 1'b0, 0);
        expect_rsp("R8 io still live", 1, 0, 0, 0, 1);

        // R5: foreign requester id
        do_reset();
        send_req(0, 7);
        send_cpl(16'h0200, 0, 1'b1, 0);
        check("R5 foreign no rsp", rsp_valid, 0);
        check("R5 foreign no unexp", unexp_cpl, 0);
        peek(0, 1);
        check("R5 entry kept", req_tag, 1);
        send_cpl(LID, 0, 1'b1, 0);
        expect_rsp("R5 own accepted", 0, 0, 0, 1, 7);

        // R4: length limits
        do_reset();
        send_req(2, 1024);
        check("R4 write 1024 ok", req_malformed, 0);
        send_req(2, 1025);
        check("R4 write 1025 bad", req_malformed, 1);
        send_req(0, 0);
        check("R4 read 0 bad", req_malformed, 1);
        send_req(0, 1025);
        check("R4 read 1025 bad", req_malformed, 1);
        peek(0, 1);
        check("R4 bad read no tag", req_tag, 0);
        send_req(0, 1024);
        check("R4 read 1024 ok", req_malformed, 0);
        send_req(1, 2);
        check("R4 io 2 bad", req_malformed, 1);
        send_req(1, 0);
        check("R4 io 0 bad", req_malformed, 1);
        peek(0, 1);
        check("R4 bad io no tag", req_tag, 1);
        send_req(1, 1);
        check("R4 io 1 ok", req_malformed, 0);
        peek(0, 1);
        check("R4 good io tagged", req_tag, 2);

        // R9: timeout cycle
        do_reset();
        send_req(0, 9);
        k0 = cyc;
        seen = 0;
        for (int n = 0; n < LIM + 10 && !rsp_valid; n++) @(negedge clk);
        seen = cyc - k0;
        check("R9 timeout cycle", seen, LIM + 1);
        expect_rsp("R9 timeout", 0, 2, 0, 0, 9);
        peek(0, 1);
        check("R9 tag freed", req_tag, 0);

        // R10: completion collides with timeout
        do_reset();
        send_req(0, 3);
        k0 = cyc;
        send_req(1, 1);
        while (cyc < k0 + LIM) @(negedge clk);
        send_cpl(LID, 1, 1'b0, 0);
        expect_rsp("R10 completion first", 1, 0, 0, 0, 1);
        @(negedge clk);
        expect_rsp("R10 timeout next", 0, 2, 0, 0, 3);
        @(negedge clk);
        check("R10 single timeout", rsp_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule